// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a bus of digital input lines and raises a single interrupt request when they change. It has two ways of deciding that a change matters. In any-edge mode, a transition in either direction on a channel whose bit is set in the change mask raises the request. In rising mode, only a low-to-high transition on channel 0 or channel 1, each selected separately, raises it. Both modes drive the same request line, so they cannot both act at once. If software enables both, any-edge mode wins, and a read-only register reports which mode is actually in force.

When the request is raised, the synchronised level of every input is frozen into a snapshot register. Software can read the snapshot instead of polling the lines. The snapshot and the request both stay as they are until software writes 1 to the clear bit, which drops the request and zeroes the snapshot together. Edges that arrive while a request is pending are not stored. An edge that falls in the same cycle as the clear is dropped.

Inputs pass through a two-stage synchroniser, and each edge is detected against a registered copy of the synchronised value. A change at the pins therefore shows on `irq` on the third rising clock edge after it. Software reaches the block through a simple single-cycle register port. Reads are combinational.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and the change mask, control, snapshot and mode registers all read 0.
- R2: In any-edge mode (control bit 0 set), a rising or a falling transition on an input whose mask bit is 1 sets `irq` on the third rising clock edge after the change at the pin, and not before.
- R3: In any-edge mode, transitions on inputs whose mask bit is 0 never raise `irq`.
- R4: When the request is raised, the snapshot (address 3) captures the synchronised input levels, with bit x set when channel x is high. The snapshot then stays unchanged while the request is pending, whatever the inputs do.
- R5: In rising mode (control bit 0 clear, and control bit 1 selecting channel 0 and/or bit 2 selecting channel 1), only a 0-to-1 transition on a selected channel raises `irq`. Falling edges, unselected channels and all other channels do nothing. In this mode the mode register (address 4) reads 2.
- R6: When control bit 0 and either source bit are set together, any-edge mode takes priority and rising mode is suppressed. The mode register reads 1, and a rising edge on a selected source whose mask bit is 0 does not raise `irq`.
- R7: Writing a value with bit 0 set to the clear register (address 2) deasserts `irq` and zeroes the snapshot on that clock edge. Writing 0 there leaves the request pending.
- R8: Edges that arrive while a request is pending are not queued, so no request follows the clear. An edge that is detected in the same cycle as a clear is dropped.
- R9: The change mask (address 0) reads back as written. The control register (address 1) reads back bits 2:0 as written, and its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | NUM_CH (16) | Asynchronous digital input lines |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 3 | Register address: 0 mask, 1 control, 2 clear, 3 snapshot, 4 mode |
| reg_wdata | input | NUM_CH (16) | Write data |
| reg_rdata | output | NUM_CH (16) | Combinational read data for `reg_addr` |
| irq | output | 1 | Shared interrupt request, high while pending |

## Verification
The bench drives both rising and falling transitions on a masked channel to show that any-edge mode sees both directions. It changes a masked and an unmasked channel together to show that the mask is honoured, and that the snapshot holds the captured level rather than the current one. In rising mode it drives the falling edge of a selected source, the rising edge of an unselected source, and the rising edge of a selected source, which separates direction filtering from source selection. It also enables both modes at once with a zero mask, which shows that priority suppresses rising mode. Finally, it times a clear to coincide with a detected edge, so that a design which queues edges can be told apart from one that drops them.

// File: rtl/cos_irq_pkg.sv
// Package: shared constants and types for the change-of-state interrupt
// controller. Assumes a 3-bit word address on the register port.
package cos_irq_pkg;

    localparam int ADDR_W = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLEAR = 3'd2;
    localparam logic [ADDR_W-1:0] A_SNAP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;

    // Control register bit positions
    localparam int CTL_ANY  = 0;
    localparam int CTL_SRC0 = 1;
    localparam int CTL_SRC1 = 2;
    localparam int CTL_W    = 3;

    // Clear register bit position
    localparam int CLR_BIT = 0;

    // Mode actually in effect
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_ANY  = 2'd1,
        MODE_RISE = 2'd2
    } mode_e;

endpackage

// File: rtl/cos_sync.sv
// Module: cos_sync
// Multi-stage flip-flop synchroniser for a bus of asynchronous inputs.
// Assumes the bits are independent levels; no bus coherency is implied.
module cos_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[i] <= '0;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/cos_detect.sv
// Module: cos_detect
// Resolves the mode in effect and flags a qualifying edge on the
// synchronised inputs. Any-edge mode has priority over rising mode.
// Assumes W >= 2, so that channels 0 and 1 exist.
module cos_detect
    import cos_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync,
    input  logic [W-1:0] mask,
    input  logic         any_en,
    input  logic [1:0]   src_en,
    output logic         edge_hit,
    output mode_e        mode
);

    logic [W-1:0] prev_q;
    logic         any_hit;
    logic         rise_hit;

    // Registered copy of the synchronised inputs, used as the edge reference
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync;
    end

    // Resolve the mode in force; any-edge mode suppresses rising mode
    always_comb begin
        if (any_en)          mode = MODE_ANY;
        else if (|src_en)    mode = MODE_RISE;
        else                 mode = MODE_OFF;
    end

    // Edge qualification for each mode
    always_comb begin
        any_hit  = |((sync ^ prev_q) & mask);
        rise_hit = |(sync[1:0] & ~prev_q[1:0] & src_en);
        unique case (mode)
            MODE_ANY:  edge_hit = any_hit;
            MODE_RISE: edge_hit = rise_hit;
            default:   edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cos_latch.sv
// Module: cos_latch
// Holds the pending request and the frozen input snapshot. A clear wins
// over an edge that arrives in the same cycle; that edge is dropped.
module cos_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_hit,
    input  logic         clr_req,
    input  logic [W-1:0] sync,
    output logic         pending,
    output logic [W-1:0] snap
);

    // Request and snapshot update: set on a fresh edge, cleared on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            snap    <= '0;
        end else if (clr_req) begin
            pending <= 1'b0;
            snap    <= '0;
        end else if (edge_hit && !pending) begin
            pending <= 1'b1;
            snap    <= sync;
        end
    end

endmodule

// File: rtl/cos_regs.sv
// Module: cos_regs
// Software-visible register file: the change mask, the control bits, the
// clear strobe and the read mux. Assumes single-cycle writes and
// combinational reads.
module cos_regs
    import cos_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      snap,
    input  mode_e             mode,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      mask,
    output logic              any_en,
    output logic [1:0]        src_en,
    output logic              clr_req
);

    logic [CTL_W-1:0] ctrl_q;

    // Writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            if (addr == A_MASK) mask   <= wdata;
            if (addr == A_CTRL) ctrl_q <= wdata[CTL_W-1:0];
        end
    end

    assign any_en  = ctrl_q[CTL_ANY];
    assign src_en  = {ctrl_q[CTL_SRC1], ctrl_q[CTL_SRC0]};
    assign clr_req = wr && (addr == A_CLEAR) && wdata[CLR_BIT];

    // Read mux
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MASK:  rdata = mask;
            A_CTRL:  rdata[CTL_W-1:0] = ctrl_q;
            A_SNAP:  rdata = snap;
            A_MODE:  rdata[1:0] = mode;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/cos_irq_ctrl.sv
// Module: cos_irq_ctrl (top)
// Change-of-state interrupt controller: synchronises NUM_CH input lines,
// detects any-edge or rising-edge events, latches an input snapshot and
// drives one interrupt request until a write-1 clear.
// Assumes NUM_CH >= 3 so that the control bits fit the data bus.
module cos_irq_ctrl
    import cos_irq_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NUM_CH-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_rdata,
    output logic              irq
);

    logic [NUM_CH-1:0] sync_v;
    logic [NUM_CH-1:0] mask_v;
    logic [NUM_CH-1:0] snap_q;
    logic              any_en;
    logic [1:0]        src_en;
    logic              clr_req;
    logic              edge_hit;
    mode_e             mode_cur;

    cos_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (din),
        .q (sync_v)
    );

    cos_detect #(.W(NUM_CH)) u_detect (
        .clk (clk),
        .rst_n (rst_n),
        .sync (sync_v),
        .mask (mask_v),
        .any_en (any_en),
        .src_en (src_en),
        .edge_hit (edge_hit),
        .mode (mode_cur)
    );

    cos_latch #(.W(NUM_CH)) u_latch (
        .clk (clk),
        .rst_n (rst_n),
        .edge_hit (edge_hit),
        .clr_req (clr_req),
        .sync (sync_v),
        .pending (irq),
        .snap (snap_q)
    );

    cos_regs #(.W(NUM_CH)) u_regs (
        .clk (clk),
        .rst_n (rst_n),
        .wr (reg_wr),
        .addr (reg_addr),
        .wdata (reg_wdata),
        .snap (snap_q),
        .mode (mode_cur),
        .rdata (reg_rdata),
        .mask (mask_v),
        .any_en (any_en),
        .src_en (src_en),
        .clr_req (clr_req)
    );

endmodule

// File: rtl/cos_irq_ctrl_chk.sv
// Module: cos_irq_ctrl_chk
// Assertion checker bound to cos_irq_ctrl. It watches the register port,
// the request and the snapshot.
module cos_irq_ctrl_chk
    import cos_irq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NUM_CH-1:0] reg_wdata,
    input logic              irq,
    input logic [NUM_CH-1:0] snap,
    input logic [1:0]        mode
);

    logic clr_seen;
    assign clr_seen = reg_wr && (reg_addr == A_CLEAR) && reg_wdata[CLR_BIT];

    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_seen |=> !irq);

    p_snap_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (snap == '0));

    p_snap_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_seen) |=> $stable(snap));

    p_request_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_seen) |=> irq);

    p_rise_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && ($past(mode) == MODE_RISE)) |-> (snap[1:0] != 2'b00));

    p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .reg_wr (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata (reg_wdata),
    .irq (irq),
    .snap (snap_q),
    .mode (mode_cur)
);

// File: tb/cos_irq_ctrl_test.sv
// Directed bench for cos_irq_ctrl: one task per scenario, each checking itself.
module cos_irq_ctrl_test;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] din = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    cos_irq_ctrl #(.NUM_CH(N)) uut (
        .clk (clk),
        .rst_n (rst_n),
        .din (din),
        .reg_wr (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Change the inputs and expect irq exactly on the third edge
    task automatic expect_fire(input logic [N-1:0] v, input string req);
        din = v;
        wait_cyc(2);
        chk({req, " irq early"}, irq, 0);
        wait_cyc(1);
        chk({req, " irq raised"}, irq, 1);
    endtask

    task automatic expect_quiet(input logic [N-1:0] v, input string req);
        din = v;
        wait_cyc(5);
        chk({req, " irq quiet"}, irq, 0);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        chk("R1 irq", irq, 0);
        rd(3'd0, d); chk("R1 mask", d, 0);
        rd(3'd1, d); chk("R1 ctrl", d, 0);
        rd(3'd3, d); chk("R1 snap", d, 0);
        rd(3'd4, d); chk("R1 mode", d, 0);
        wr(3'd0, 16'hBEEF); rd(3'd0, d); chk("R9 mask readback", d, 16'hBEEF);
        wr(3'd1, 16'hFFFF); rd(3'd1, d); chk("R9 ctrl readback", d, 16'h0007);
        wr(3'd1, 16'h0000);
    endtask

    task automatic t_any_edge();
        logic [N-1:0] d;
        wr(3'd0, 16'h0004);
        wr(3'd1, 16'h0001);
        expect_fire(16'h0004, "R2 rise ch2");
        rd(3'd3, d); chk("R4 snap capture", d, 16'h0004);
        din = 16'h0020;
        wait_cyc(4);
        chk("R8 pending held", irq, 1);
        rd(3'd3, d); chk("R4 snap frozen", d, 16'h0004);
        wr(3'd2, 16'h0001);
        chk("R7 clear irq", irq, 0);
        rd(3'd3, d); chk("R7 snap zeroed", d, 0);
        wait_cyc(4);
        chk("R8 no queued request", irq, 0);
        expect_fire(16'h0024, "R2 rise again");
        wr(3'd2, 16'h0001);
        expect_fire(16'h0020, "R2 fall ch2");
        rd(3'd3, d); chk("R4 snap after fall", d, 16'h0020);
        wr(3'd2, 16'h0001);
    endtask

    task automatic t_masked();
        expect_quiet(16'h00A0, "R3 unmasked ch7");
        expect_quiet(16'h0020, "R3 unmasked ch7 fall");
    endtask

    task automatic t_clear();
        expect_fire(16'h0024, "R2 arm");
        wr(3'd2, 16'h0000);
        chk("R7 zero write keeps irq", irq, 1);
        din = 16'h0020;
        wait_cyc(2);
        wr(3'd2, 16'h0001);
        chk("R8 race clear", irq, 0);
        wait_cyc(4);
        chk("R8 race edge dropped", irq, 0);
    endtask

    task automatic t_rise();
        logic [N-1:0] d;
        wr(3'd1, 16'h0002);
        rd(3'd4, d); chk("R5 mode rise", d, 2);
        expect_fire(16'h0021, "R5 ch0 rise");
        rd(3'd3, d); chk("R5 snap", d, 16'h0021);
        wr(3'd2, 16'h0001);
        expect_quiet(16'h0020, "R5 ch0 fall");
        expect_quiet(16'h0026, "R5 ch1 unselected and ch2");
        wr(3'd1, 16'h0006);
        expect_quiet(16'h0024, "R5 ch1 fall");
        expect_fire(16'h0026, "R5 ch1 rise");
        wr(3'd2, 16'h0001);
    endtask

    task automatic t_priority();
        logic [N-1:0] d;
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0003);
        rd(3'd4, d); chk("R6 mode any wins", d, 1);
        expect_quiet(16'h0027, "R6 rise suppressed");
        wr(3'd0, 16'h0001);
        expect_fire(16'h0026, "R6 any-edge fall ch0");
        wr(3'd2, 16'h0001);
        wr(3'd1, 16'h0000);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_any_edge();
        t_masked();
        t_clear();
        t_rise();
        t_priority();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule